// File: doc/BRIEF.md
# PHY Power-Up and Reset Sequencer

This block brings a combined USB2/USB3 PHY and the USB controller beside it out of reset in a fixed order after a single start pulse. It drives the four active-low reset lines, the USB2 low-power (IDDQ) and USB3 test-power-down controls, the three power-good indications, the PLL spread-spectrum enable and the forced VBUS-valid overrides. Between some steps it holds off for a programmable number of microseconds. The delay comes from a parameter that gives system clocks per microsecond.

The last step is a read-modify-write of one PHY register through an external control-register access port. The port is a request/response handshake and is not part of this block. The block reads the register and ORs in a boost-enable bit and a boost-level field. It then writes the result back. A read that times out is retried a bounded number of times. Any other failure ends the sequence with an error flag.

A separate shutdown pulse, accepted only while the block is idle, puts the PHY back into reset and leaves the controller alone. The status outputs `busy`, `done` and `error` tell the surrounding logic where the sequence stands.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, all four reset outputs are 0 (held), `u2Iddq` and `u3TestPd` are 1, the power flags, `sscEn`, the four VBUS overrides, `regReq`, `busy`, `done` and `error` are 0.
- R2: A start pulse accepted while idle raises `busy` and holds all four resets. With the resets still held, it clears `u2Iddq` first and then clears `u3TestPd` on a later cycle.
- R3: `u3PhyRstN` and `u2PorN` are released together, after both low-power exits, while `auxRstN` and `ctrlRstN` are still held.
- R4: `anaPwrEn`, `pcsPwrStable` and `pmaPwrStable` rise together, no earlier than DELAY_US×CLKS_PER_US cycles after the PHY reset release.
- R5: `sscEn` rises on a cycle strictly before `auxRstN` and `ctrlRstN`, which are released together after the power flags.
- R6: `u3VbusForce`, `u3VbusSel`, `u2VbusExt` and `u2VbusExtSel` rise together, no earlier than DELAY_US×CLKS_PER_US cycles after the controller reset release.
- R7: The first read request (`regReq`=1, `regWrite`=0, `regAddr`=0x000F) starts no earlier than DELAY_US×CLKS_PER_US cycles after the VBUS overrides. A request is held, with `regWrite` stable, until a one-cycle `regAck`, `regTimeout` or `regErr` pulse.
- R8: After a read acknowledge, a write to address 0x000F carries the read data ORed with bit 9 set and with BOOST_LVL shifted left by 6 (default 5, giving 0x0343 for read data 0x0003). A write acknowledge sets `done` and clears `busy`.
- R9: A read that ends in `regTimeout` is reissued. At most MAX_READS (3) reads are made in total, and a timeout on the last one sets `error`.
- R10: `regErr` on a read, or `regTimeout`/`regErr` on the write, sets `error`, clears `busy`, leaves `done` at 0 and issues no further requests.
- R11: A start pulse while `busy` is 1 is ignored. The running sequence continues without re-asserting any reset.
- R12: A shutdown pulse while idle drives `u3PhyRstN` and `u2PorN` to 0 and leaves every other output unchanged. A shutdown pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to run the bring-up sequence |
| stopReq | input | 1 | One-cycle request to put the PHY back into reset |
| auxRstN | output | 1 | Auxiliary power-domain reset, 0 = held |
| ctrlRstN | output | 1 | Controller reset, 0 = held |
| u3PhyRstN | output | 1 | USB3 PHY reset, 0 = held |
| u2PorN | output | 1 | USB2 PHY power-on reset, 0 = held |
| u2Iddq | output | 1 | USB2 PHY low-power mode, 1 = in low power |
| u3TestPd | output | 1 | USB3 PHY test power-down, 1 = powered down |
| anaPwrEn | output | 1 | PHY analog power enable |
| pcsPwrStable | output | 1 | PCS supply reported stable |
| pmaPwrStable | output | 1 | PMA supply reported stable |
| sscEn | output | 1 | PLL spread-spectrum enable |
| u3VbusForce | output | 1 | Forced USB3 VBUS-valid value |
| u3VbusSel | output | 1 | Selects the forced USB3 VBUS-valid |
| u2VbusExt | output | 1 | Forced USB2 external VBUS-valid value |
| u2VbusExtSel | output | 1 | Selects the forced USB2 external VBUS-valid |
| regReq | output | 1 | Register access request, held until a response |
| regWrite | output | 1 | 1 = write, 0 = read |
| regAddr | output | 16 | PHY register address |
| regWdata | output | 16 | Write data |
| regRdata | input | 16 | Read data, valid with `regAck` |
| regAck | input | 1 | Access completed successfully |
| regTimeout | input | 1 | Access timed out |
| regErr | input | 1 | Access failed for another reason |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |
| error | output | 1 | Last sequence aborted |

## Verification
The bound checker watches every cycle for the things that hold at each edge. It checks that each step follows its predecessor: low-power exits only while all resets are held, and the PHY release only after both exits. It also checks that the power flags and VBUS overrides rise as groups, that each of the three waits lasts the full window (measured with its own saturating counters), that a pending access request holds steady, and that a shutdown drops the two PHY resets together. Other behaviours depend on the data and on how the sequence ends, so only the bench scenarios can show them. These are the read-modify-write value, the retry count under repeated timeouts, the abort paths, and that start and shutdown pulses are ignored mid-run.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD, ST_IDDQ, ST_TPD, ST_WAIT_PHY, ST_PWR, ST_SSC, ST_CTRL,
    ST_WAIT_CTRL, ST_VBUS, ST_WAIT_VBUS, ST_RD_ISSUE, ST_RD_WAIT,
    ST_WR_ISSUE, ST_WR_WAIT
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic holdAll;
    logic clrIddq;
    logic clrTpd;
    logic relPhy;
    logic setPwr;
    logic setSsc;
    logic relCtrl;
    logic setVbus;
    logic loadDly;
    logic incRetry;
    logic capRead;
    logic shutdown;
    logic clrStat;
    logic setDone;
    logic setErr;
  } seqStrobe_t;

endpackage

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       dlyZero,
  input  logic       retryLast,
  input  logic       regAck,
  input  logic       regTimeout,
  input  logic       regErr,
  output seqStrobe_t strb,
  output logic       regReq,
  output logic       regWrite,
  output logic       busy
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    regReq   = 1'b0;
    regWrite = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.holdAll = 1'b1;
          strb.clrStat = 1'b1;
          stateNxt     = ST_HOLD;
        end else if (stopReq) begin
          strb.shutdown = 1'b1;
        end
      end
      ST_HOLD: begin
        strb.clrIddq = 1'b1;
        stateNxt     = ST_IDDQ;
      end
      ST_IDDQ: begin
        strb.clrTpd = 1'b1;
        stateNxt    = ST_TPD;
      end
      ST_TPD: begin
        strb.relPhy  = 1'b1;
        strb.loadDly = 1'b1;
        stateNxt     = ST_WAIT_PHY;
      end
      ST_WAIT_PHY: if (dlyZero) stateNxt = ST_PWR;
      ST_PWR: begin
        strb.setPwr = 1'b1;
        stateNxt    = ST_SSC;
      end
      ST_SSC: begin
        strb.setSsc = 1'b1;
        stateNxt    = ST_CTRL;
      end
      ST_CTRL: begin
        strb.relCtrl = 1'b1;
        strb.loadDly = 1'b1;
        stateNxt     = ST_WAIT_CTRL;
      end
      ST_WAIT_CTRL: if (dlyZero) stateNxt = ST_VBUS;
      ST_VBUS: begin
        strb.setVbus = 1'b1;
        strb.loadDly = 1'b1;
        stateNxt     = ST_WAIT_VBUS;
      end
      ST_WAIT_VBUS: if (dlyZero) stateNxt = ST_RD_ISSUE;
      ST_RD_ISSUE: stateNxt = ST_RD_WAIT;
      ST_RD_WAIT: begin
        regReq = 1'b1;
        if (regErr) begin
          strb.setErr = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (regTimeout) begin
          if (retryLast) begin
            strb.setErr = 1'b1;
            stateNxt    = ST_IDLE;
          end else begin
            strb.incRetry = 1'b1;
            stateNxt      = ST_RD_ISSUE;
          end
        end else if (regAck) begin
          strb.capRead = 1'b1;
          stateNxt     = ST_WR_ISSUE;
        end
      end
      ST_WR_ISSUE: stateNxt = ST_WR_WAIT;
      ST_WR_WAIT: begin
        regReq   = 1'b1;
        regWrite = 1'b1;
        if (regErr || regTimeout) begin
          strb.setErr = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (regAck) begin
          strb.setDone = 1'b1;
          stateNxt     = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/phy_seq_dpath.sv
module phy_seq_dpath
  import phy_seq_pkg::*;
#(
  parameter int CLKS_PER_US  = 50,
  parameter int DELAY_US     = 100,
  parameter int MAX_READS    = 3,
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 16,
  parameter int BOOST_REG    = 15,
  parameter int BOOST_LVL    = 5,
  parameter int BOOST_SHIFT  = 6,
  parameter int BOOST_EN_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [DATA_W-1:0] regRdata,
  output logic              dlyZero,
  output logic              retryLast,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              auxRstN,
  output logic              ctrlRstN,
  output logic              u3PhyRstN,
  output logic              u2PorN,
  output logic              u2Iddq,
  output logic              u3TestPd,
  output logic              anaPwrEn,
  output logic              pcsPwrStable,
  output logic              pmaPwrStable,
  output logic              sscEn,
  output logic              u3VbusForce,
  output logic              u3VbusSel,
  output logic              u2VbusExt,
  output logic              u2VbusExtSel,
  output logic              done,
  output logic              error
);

  localparam int DLY_CYC = CLKS_PER_US * DELAY_US;
  localparam int CNT_W   = $clog2(DLY_CYC + 1);
  localparam int RETRY_W = $clog2(MAX_READS + 1);
  localparam logic [DATA_W-1:0] EN_MASK    = DATA_W'(1) << BOOST_EN_BIT;
  localparam logic [DATA_W-1:0] LVL_FIELD  = DATA_W'(BOOST_LVL) << BOOST_SHIFT;

  logic [CNT_W-1:0]   dlyCnt;
  logic [RETRY_W-1:0] retryCnt;
  logic [DATA_W-1:0]  readReg;

  // reset / power control lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      auxRstN      <= 1'b0;
      ctrlRstN     <= 1'b0;
      u3PhyRstN    <= 1'b0;
      u2PorN       <= 1'b0;
      u2Iddq       <= 1'b1;
      u3TestPd     <= 1'b1;
      anaPwrEn     <= 1'b0;
      pcsPwrStable <= 1'b0;
      pmaPwrStable <= 1'b0;
      sscEn        <= 1'b0;
    end else begin
      if (strb.holdAll) begin
        auxRstN      <= 1'b0;
        ctrlRstN     <= 1'b0;
        u3PhyRstN    <= 1'b0;
        u2PorN       <= 1'b0;
        u2Iddq       <= 1'b1;
        u3TestPd     <= 1'b1;
        anaPwrEn     <= 1'b0;
        pcsPwrStable <= 1'b0;
        pmaPwrStable <= 1'b0;
        sscEn        <= 1'b0;
      end
      if (strb.clrIddq) u2Iddq   <= 1'b0;
      if (strb.clrTpd)  u3TestPd <= 1'b0;
      if (strb.relPhy) begin
        u3PhyRstN <= 1'b1;
        u2PorN    <= 1'b1;
      end
      if (strb.setPwr) begin
        anaPwrEn     <= 1'b1;
        pcsPwrStable <= 1'b1;
        pmaPwrStable <= 1'b1;
      end
      if (strb.setSsc) sscEn <= 1'b1;
      if (strb.relCtrl) begin
        auxRstN  <= 1'b1;
        ctrlRstN <= 1'b1;
      end
      if (strb.shutdown) begin
        u3PhyRstN <= 1'b0;
        u2PorN    <= 1'b0;
      end
    end
  end

  // VBUS override group
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      u3VbusForce  <= 1'b0;
      u3VbusSel    <= 1'b0;
      u2VbusExt    <= 1'b0;
      u2VbusExtSel <= 1'b0;
    end else if (strb.holdAll) begin
      u3VbusForce  <= 1'b0;
      u3VbusSel    <= 1'b0;
      u2VbusExt    <= 1'b0;
      u2VbusExtSel <= 1'b0;
    end else if (strb.setVbus) begin
      u3VbusForce  <= 1'b1;
      u3VbusSel    <= 1'b1;
      u2VbusExt    <= 1'b1;
      u2VbusExtSel <= 1'b1;
    end
  end

  // microsecond-window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dlyCnt <= '0;
    else if (strb.loadDly)   dlyCnt <= CNT_W'(DLY_CYC - 1);
    else if (dlyCnt != '0)   dlyCnt <= dlyCnt - 1'b1;
  end
  assign dlyZero = (dlyCnt == '0);

  // read retry counter and captured read data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryCnt <= '0;
      readReg  <= '0;
    end else begin
      if (strb.holdAll)       retryCnt <= '0;
      else if (strb.incRetry) retryCnt <= retryCnt + 1'b1;
      if (strb.capRead)       readReg  <= regRdata;
    end
  end
  assign retryLast = (retryCnt == RETRY_W'(MAX_READS - 1));

  assign regAddr  = ADDR_W'(BOOST_REG);
  assign regWdata = readReg | EN_MASK | LVL_FIELD;

  // status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done  <= 1'b0;
      error <= 1'b0;
    end else if (strb.clrStat) begin
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      if (strb.setDone) done  <= 1'b1;
      if (strb.setErr)  error <= 1'b1;
    end
  end

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int CLKS_PER_US  = 50,
  parameter int DELAY_US     = 100,
  parameter int MAX_READS    = 3,
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 16,
  parameter int BOOST_REG    = 15,
  parameter int BOOST_LVL    = 5,
  parameter int BOOST_SHIFT  = 6,
  parameter int BOOST_EN_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  output logic              auxRstN,
  output logic              ctrlRstN,
  output logic              u3PhyRstN,
  output logic              u2PorN,
  output logic              u2Iddq,
  output logic              u3TestPd,
  output logic              anaPwrEn,
  output logic              pcsPwrStable,
  output logic              pmaPwrStable,
  output logic              sscEn,
  output logic              u3VbusForce,
  output logic              u3VbusSel,
  output logic              u2VbusExt,
  output logic              u2VbusExtSel,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              regAck,
  input  logic              regTimeout,
  input  logic              regErr,
  output logic              busy,
  output logic              done,
  output logic              error
);

  seqStrobe_t strb;
  logic       dlyZero;
  logic       retryLast;

  phy_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .stopReq    (stopReq),
    .dlyZero    (dlyZero),
    .retryLast  (retryLast),
    .regAck     (regAck),
    .regTimeout (regTimeout),
    .regErr     (regErr),
    .strb       (strb),
    .regReq     (regReq),
    .regWrite   (regWrite),
    .busy       (busy)
  );

  phy_seq_dpath #(
    .CLKS_PER_US (CLKS_PER_US),
    .DELAY_US    (DELAY_US),
    .MAX_READS   (MAX_READS),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .BOOST_REG   (BOOST_REG),
    .BOOST_LVL   (BOOST_LVL),
    .BOOST_SHIFT (BOOST_SHIFT),
    .BOOST_EN_BIT(BOOST_EN_BIT)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .regRdata     (regRdata),
    .dlyZero      (dlyZero),
    .retryLast    (retryLast),
    .regAddr      (regAddr),
    .regWdata     (regWdata),
    .auxRstN      (auxRstN),
    .ctrlRstN     (ctrlRstN),
    .u3PhyRstN    (u3PhyRstN),
    .u2PorN       (u2PorN),
    .u2Iddq       (u2Iddq),
    .u3TestPd     (u3TestPd),
    .anaPwrEn     (anaPwrEn),
    .pcsPwrStable (pcsPwrStable),
    .pmaPwrStable (pmaPwrStable),
    .sscEn        (sscEn),
    .u3VbusForce  (u3VbusForce),
    .u3VbusSel    (u3VbusSel),
    .u2VbusExt    (u2VbusExt),
    .u2VbusExtSel (u2VbusExtSel),
    .done         (done),
    .error        (error)
  );

endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk #(
  parameter int CLKS_PER_US = 50,
  parameter int DELAY_US    = 100
) (
  input logic clk,
  input logic rstN,
  input logic auxRstN,
  input logic ctrlRstN,
  input logic u3PhyRstN,
  input logic u2PorN,
  input logic u2Iddq,
  input logic u3TestPd,
  input logic anaPwrEn,
  input logic pcsPwrStable,
  input logic pmaPwrStable,
  input logic sscEn,
  input logic u3VbusForce,
  input logic u3VbusSel,
  input logic u2VbusExt,
  input logic u2VbusExtSel,
  input logic regReq,
  input logic regWrite,
  input logic regAck,
  input logic regTimeout,
  input logic regErr,
  input logic done,
  input logic error
);

  localparam int DLY_CYC = CLKS_PER_US * DELAY_US;
  localparam int AGE_W   = $clog2(DLY_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(DLY_CYC);

  logic [AGE_W-1:0] phyAge, ctrlAge, vbusAge;

  // saturating cycle counts since each release/override went high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyAge  <= '0;
      ctrlAge <= '0;
      vbusAge <= '0;
    end else begin
      if (!u3PhyRstN)             phyAge <= '0;
      else if (phyAge < AGE_MAX)  phyAge <= phyAge + 1'b1;
      if (!ctrlRstN)              ctrlAge <= '0;
      else if (ctrlAge < AGE_MAX) ctrlAge <= ctrlAge + 1'b1;
      if (!u3VbusForce)           vbusAge <= '0;
      else if (vbusAge < AGE_MAX) vbusAge <= vbusAge + 1'b1;
    end
  end

  assert_iddq_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(u2Iddq) |-> (!auxRstN && !ctrlRstN && !u3PhyRstN && !u2PorN));

  assert_tpd_after_iddq_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(u3TestPd) |-> (!u2Iddq && !$past(u2Iddq) && !u3PhyRstN && !u2PorN && !auxRstN));

  assert_phy_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(u3PhyRstN) |-> (u2PorN && !u2Iddq && !u3TestPd && !auxRstN && !ctrlRstN));

  assert_pwr_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pcsPwrStable) |-> (anaPwrEn && pmaPwrStable && phyAge >= AGE_MAX));

  assert_ssc_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(auxRstN) |-> (ctrlRstN && sscEn && $past(sscEn) && pcsPwrStable));

  assert_vbus_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(u3VbusForce) |-> (u3VbusSel && u2VbusExt && u2VbusExtSel && ctrlAge >= AGE_MAX));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck && !regTimeout && !regErr) |=> (regReq && $stable(regWrite)));

  assert_read_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regReq) |-> (vbusAge >= AGE_MAX));

  assert_status_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  assert_phy_pair_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(u3PhyRstN) |-> $fell(u2PorN));

endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(
  .CLKS_PER_US (CLKS_PER_US),
  .DELAY_US    (DELAY_US)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .auxRstN      (auxRstN),
  .ctrlRstN     (ctrlRstN),
  .u3PhyRstN    (u3PhyRstN),
  .u2PorN       (u2PorN),
  .u2Iddq       (u2Iddq),
  .u3TestPd     (u3TestPd),
  .anaPwrEn     (anaPwrEn),
  .pcsPwrStable (pcsPwrStable),
  .pmaPwrStable (pmaPwrStable),
  .sscEn        (sscEn),
  .u3VbusForce  (u3VbusForce),
  .u3VbusSel    (u3VbusSel),
  .u2VbusExt    (u2VbusExt),
  .u2VbusExtSel (u2VbusExtSel),
  .regReq       (regReq),
  .regWrite     (regWrite),
  .regAck       (regAck),
  .regTimeout   (regTimeout),
  .regErr       (regErr),
  .done         (done),
  .error        (error)
);

// File: tb/phy_bringup_seq_test.sv
module phy_bringup_seq_test;

  localparam int CPU = 2;
  localparam int DLY = CPU * 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic stopReq = 1'b0;
  logic auxRstN, ctrlRstN, u3PhyRstN, u2PorN, u2Iddq, u3TestPd;
  logic anaPwrEn, pcsPwrStable, pmaPwrStable, sscEn;
  logic u3VbusForce, u3VbusSel, u2VbusExt, u2VbusExtSel;
  logic regReq, regWrite;
  logic [15:0] regAddr, regWdata;
  logic [15:0] regRdata = 16'h0;
  logic regAck = 1'b0, regTimeout = 1'b0, regErr = 1'b0;
  logic busy, done, error;

  always #10 clk = ~clk;

  phy_bringup_seq #(.CLKS_PER_US(CPU)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .auxRstN(auxRstN), .ctrlRstN(ctrlRstN), .u3PhyRstN(u3PhyRstN), .u2PorN(u2PorN),
    .u2Iddq(u2Iddq), .u3TestPd(u3TestPd), .anaPwrEn(anaPwrEn),
    .pcsPwrStable(pcsPwrStable), .pmaPwrStable(pmaPwrStable), .sscEn(sscEn),
    .u3VbusForce(u3VbusForce), .u3VbusSel(u3VbusSel), .u2VbusExt(u2VbusExt),
    .u2VbusExtSel(u2VbusExtSel), .regReq(regReq), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .regAck(regAck),
    .regTimeout(regTimeout), .regErr(regErr), .busy(busy), .done(done), .error(error)
  );

  int nChecks = 0;
  int nFails  = 0;

  // responder configuration and observations
  int          cfgRdTimeouts = 0;
  bit          cfgRdErr = 1'b0;
  bit          cfgWrTimeout = 1'b0;
  logic [15:0] cfgRdVal = 16'h0003;
  int          rdCount = 0;
  int          wrCount = 0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdAddr = 16'h0;
  logic [15:0] wrAddr = 16'h0;

  // event timestamps recorded by runSeq
  int tIddq, tTpd, tPhy, tPwr, tSsc, tAux, tVbus, tReq;
  int nPhyRise, nPhyFall;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin : responder
    forever begin
      @(negedge clk);
      if (regReq) begin
        if (regWrite) begin
          wrCount++;
          wrData = regWdata;
          wrAddr = regAddr;
          repeat (2) @(negedge clk);
          if (cfgWrTimeout) regTimeout = 1'b1;
          else              regAck = 1'b1;
        end else begin
          rdCount++;
          rdAddr = regAddr;
          repeat (2) @(negedge clk);
          if (cfgRdErr)                     regErr = 1'b1;
          else if (rdCount <= cfgRdTimeouts) regTimeout = 1'b1;
          else begin
            regRdata = cfgRdVal;
            regAck   = 1'b1;
          end
        end
        @(negedge clk);
        regAck = 1'b0;
        regTimeout = 1'b0;
        regErr = 1'b0;
      end
    end
  end

  // start one sequence and follow it to the end; pokeAt > 0 pulses start and stop mid-run
  task automatic runSeq(input int pokeAt);
    int cyc = 0;
    logic pIddq, pTpd, pPhy, pPwr, pSsc, pAux, pVbus, pReq;
    tIddq = -1; tTpd = -1; tPhy = -1; tPwr = -1; tSsc = -1; tAux = -1;
    tVbus = -1; tReq = -1; nPhyRise = 0; nPhyFall = 0;
    rdCount = 0; wrCount = 0;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    pIddq = u2Iddq; pTpd = u3TestPd; pPhy = u3PhyRstN; pPwr = pcsPwrStable;
    pSsc = sscEn; pAux = auxRstN; pVbus = u3VbusForce; pReq = regReq;
    while (busy && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == pokeAt) begin
        startReq = 1'b1;
        stopReq  = 1'b1;
      end else begin
        startReq = 1'b0;
        stopReq  = 1'b0;
      end
      if (pIddq && !u2Iddq && tIddq < 0) tIddq = cyc;
      if (pTpd && !u3TestPd && tTpd < 0) tTpd = cyc;
      if (!pPhy && u3PhyRstN) begin
        nPhyRise++;
        if (tPhy < 0) tPhy = cyc;
      end
      if (pPhy && !u3PhyRstN && tPhy >= 0) nPhyFall++;
      if (!pPwr && pcsPwrStable && tPwr < 0) tPwr = cyc;
      if (!pSsc && sscEn && tSsc < 0) tSsc = cyc;
      if (!pAux && auxRstN && tAux < 0) tAux = cyc;
      if (!pVbus && u3VbusForce && tVbus < 0) tVbus = cyc;
      if (!pReq && regReq && tReq < 0) tReq = cyc;
      pIddq = u2Iddq; pTpd = u3TestPd; pPhy = u3PhyRstN; pPwr = pcsPwrStable;
      pSsc = sscEn; pAux = auxRstN; pVbus = u3VbusForce; pReq = regReq;
    end
    startReq = 1'b0;
    stopReq  = 1'b0;
  endtask

  task automatic testReset();
    check(!auxRstN && !ctrlRstN && !u3PhyRstN && !u2PorN, "R1 resets held",
          {auxRstN, ctrlRstN, u3PhyRstN, u2PorN}, 4'b0000);
    check(u2Iddq && u3TestPd, "R1 low-power controls", {u2Iddq, u3TestPd}, 2'b11);
    check({anaPwrEn, pcsPwrStable, pmaPwrStable, sscEn, u3VbusForce, u3VbusSel,
           u2VbusExt, u2VbusExtSel} == 8'h0, "R1 power/vbus idle",
          {anaPwrEn, pcsPwrStable, pmaPwrStable, sscEn, u3VbusForce}, 0);
    check({regReq, busy, done, error} == 4'b0, "R1 status idle",
          {regReq, busy, done, error}, 0);
  endtask

  task automatic testNominal();
    cfgRdTimeouts = 0; cfgRdErr = 0; cfgWrTimeout = 0; cfgRdVal = 16'h0003;
    runSeq(0);
    check(tIddq > 0 && tTpd > tIddq, "R2 iddq then test-pd", tTpd, tIddq + 1);
    check(tPhy > tTpd && tAux > tPhy, "R3 phy release order", tPhy, tTpd + 1);
    check(tPwr - tPhy >= DLY, "R4 power window", tPwr - tPhy, DLY);
    check(tSsc > tPwr && tSsc < tAux, "R5 ssc before ctrl release", tSsc, tAux - 1);
    check(tVbus - tAux >= DLY, "R6 vbus window", tVbus - tAux, DLY);
    check(u3VbusSel && u2VbusExt && u2VbusExtSel, "R6 vbus group",
          {u3VbusSel, u2VbusExt, u2VbusExtSel}, 3'b111);
    check(tReq - tVbus >= DLY, "R7 read window", tReq - tVbus, DLY);
    check(rdAddr == 16'h000F && rdCount == 1, "R7 read address", rdAddr, 16'h000F);
    check(wrAddr == 16'h000F && wrData == 16'h0343, "R8 write data", wrData, 16'h0343);
    check(done && !busy && !error, "R8 done status", {done, busy, error}, 3'b100);
  endtask

  task automatic testStopIdle();
    @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check(!u3PhyRstN && !u2PorN, "R12 phy resets reasserted", {u3PhyRstN, u2PorN}, 2'b00);
    check(auxRstN && ctrlRstN && sscEn && pcsPwrStable && u3VbusForce && done,
          "R12 others unchanged", {auxRstN, ctrlRstN, sscEn, pcsPwrStable, u3VbusForce, done},
          6'h3F);
  endtask

  task automatic testRetryOk();
    cfgRdTimeouts = 2; cfgRdErr = 0; cfgWrTimeout = 0; cfgRdVal = 16'h8000;
    runSeq(0);
    check(rdCount == 3, "R9 reads after two timeouts", rdCount, 3);
    check(done && !error && wrData == 16'h8340, "R9 retry completes", wrData, 16'h8340);
  endtask

  task automatic testRetryExhaust();
    cfgRdTimeouts = 5; cfgRdErr = 0; cfgWrTimeout = 0;
    runSeq(0);
    check(rdCount == 3 && wrCount == 0, "R9 read limit", rdCount, 3);
    check(error && !done && !busy, "R9 error on last timeout", {error, done, busy}, 3'b100);
  endtask

  task automatic testReadErr();
    cfgRdTimeouts = 0; cfgRdErr = 1; cfgWrTimeout = 0;
    runSeq(0);
    repeat (10) @(negedge clk);
    check(rdCount == 1 && wrCount == 0 && !regReq, "R10 read error no retry", rdCount, 1);
    check(error && !done && !busy, "R10 read error status", {error, done, busy}, 3'b100);
    cfgRdErr = 0;
  endtask

  task automatic testWriteTimeout();
    cfgRdTimeouts = 0; cfgRdErr = 0; cfgWrTimeout = 1;
    runSeq(0);
    repeat (10) @(negedge clk);
    check(wrCount == 1 && rdCount == 1 && !regReq, "R10 write timeout no retry", wrCount, 1);
    check(error && !done, "R10 write timeout status", {error, done}, 2'b10);
    cfgWrTimeout = 0;
  endtask

  task automatic testBusyIgnore();
    cfgRdTimeouts = 0; cfgRdErr = 0; cfgWrTimeout = 0; cfgRdVal = 16'h0003;
    runSeq(DLY + 100);
    check(nPhyRise == 1 && nPhyFall == 0, "R11 start ignored while busy", nPhyFall, 0);
    check(nPhyFall == 0 && u3PhyRstN, "R12 stop ignored while busy", u3PhyRstN, 1);
    check(done && !error && rdCount == 1, "R11 sequence completes", {done, error}, 2'b10);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testNominal();
    testStopIdle();
    testRetryOk();
    testRetryExhaust();
    testReadErr();
    testWriteTimeout();
    testBusyIgnore();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule